// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes one IEEE-754 binary floating-point operand and returns the integral value closest to it under a chosen rounding direction. The result stays in the same floating-point format. Exponent and fraction widths are parameters, so one description serves half, single and double precision.

A 3-bit code selects the rounding direction. A truncate input overrides that code and forces rounding toward zero. A default-NaN input makes every NaN result the canonical quiet NaN. A flush input turns subnormal operands into signed zeros before they are classified.

Two exception flags come out with each result. The invalid flag is set for a signaling NaN. The inexact flag is set when rounding discarded a nonzero fraction. The computation is combinational and the result and flags are registered, so each operand gives its result one clock later. A new operand can be accepted on every cycle.

Top module: `fp_round_integral`

## Requirements
- R1: Zeros, infinities and operands whose biased exponent is at least bias plus the fraction width are returned bit for bit unchanged, with both flags clear.
- R2: A signaling NaN (exponent all ones, fraction nonzero, fraction MSB 0) sets invalid and is returned with its fraction MSB set and its sign and payload kept. A quiet NaN (fraction MSB 1) is returned unchanged with invalid clear.
- R3: When default-NaN mode is on, every NaN operand yields the canonical NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0 (0x7E00 in half precision). A signaling NaN still sets invalid.
- R4: A nonzero operand with magnitude below one always sets inexact. Nearest-even gives magnitude one only for values strictly greater than one half. Ties-away gives magnitude one for values of one half or more. Otherwise the result is zero. The operand's sign is kept.
- R5: For magnitudes below one, toward-zero gives a signed zero. Toward +infinity gives +1 for positive operands and -0 for negative ones. Toward -infinity gives -1 for negative operands and +0 for positive ones.
- R6: An operand of magnitude one or more that still has fraction bits is rounded at its integer position by adding an increment and then clearing the discarded bits. Ties-away adds one half. Toward-zero adds nothing. Directed modes add the full discard mask only toward their own infinity. Nearest-even adds one half, except when the bits from the integer LSB down equal exactly one half, in which case it adds nothing, so ties go to even.
- R7: When the increment carries the significand past the implicit-one position, the result is renormalized: the exponent goes up by one and the fraction becomes zero.
- R8: For magnitudes of one or more, inexact is set exactly when the discarded fraction bits were nonzero. Inexact and invalid are never set together.
- R9: When truncate is 1, the result is rounded toward zero whatever the mode code.
- R10: When flush is 1, a subnormal operand gives a zero of the same sign with no flag set. When flush is 0, a subnormal operand is rounded under the below-one rules of R4 and R5.
- R11: Mode codes: 0 nearest-even, 1 toward zero, 2 toward -infinity, 3 toward +infinity, 4 nearest with ties away from zero. Codes 5, 6 and 7 behave as nearest-even.
- R12: Result and flags are registered and appear on the clock edge after the operand is sampled. A synchronous active-high reset clears the result and both flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 1+EXP_W+MAN_W | Operand: sign, biased exponent, fraction |
| rmode_i | input | 3 | Rounding-mode code (R11) |
| trunc_i | input | 1 | Force rounding toward zero |
| dnan_i | input | 1 | Default-NaN mode |
| ftz_i | input | 1 | Treat subnormal operands as zero |
| res_o | output | 1+EXP_W+MAN_W | Rounded integral result |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The result and both flags are due exactly one rising edge after the operand and controls are presented. The bench changes inputs only on falling edges and reads the outputs on the next falling edge, which is half a period after the capturing edge. It therefore holds a single operand in flight and compares that operand's outcome before it drives the next one.

The half-precision sweeps cover every operand code several times with rotating mode codes and controls. Their expected values come from a real-arithmetic model of the value, not from bit manipulation. Directed cases fix the ties, the carry into the exponent, NaN handling and subnormal flushing.

// File: rtl/rti_pkg.sv
package rti_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_INF,
    CL_QNAN,
    CL_SNAN,
    CL_BELOW_ONE,
    CL_INTEGRAL,
    CL_FRACTIONAL
  } opclass_e;

  // Truncate wins over the code; unused codes fall back to nearest-even.
  function automatic rmode_e decode_mode(input logic [2:0] code, input logic trunc);
    if (trunc) return RM_ZERO;
    case (code)
      3'd1:    return RM_ZERO;
      3'd2:    return RM_DOWN;
      3'd3:    return RM_UP;
      3'd4:    return RM_NEAR_AWAY;
      default: return RM_NEAR_EVEN;
    endcase
  endfunction

endpackage

// File: rtl/rti_classify.sv
module rti_classify
  import rti_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  input  logic                 ftz_i,
  output opclass_e             cls_o,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W-1:0]     frac_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(BIAS + MAN_W);

  logic [EXP_W-1:0] exp_raw;
  logic [MAN_W-1:0] frac_raw;
  logic             flush;

  always_comb begin
    sign_o   = op_i[EXP_W+MAN_W];
    exp_raw  = op_i[EXP_W+MAN_W-1:MAN_W];
    frac_raw = op_i[MAN_W-1:0];
    flush    = ftz_i && (exp_raw == '0);
    exp_o    = exp_raw;
    frac_o   = flush ? '0 : frac_raw;

    if (exp_raw == '1) begin
      if (frac_raw == '0)          cls_o = CL_INF;
      else if (frac_raw[MAN_W-1])  cls_o = CL_QNAN;
      else                         cls_o = CL_SNAN;
    end else if (exp_raw == '0 && frac_o == '0) begin
      cls_o = CL_ZERO;
    end else if (exp_raw < EXP_ONE) begin
      cls_o = CL_BELOW_ONE;
    end else if (exp_raw >= EXP_TOP) begin
      cls_o = CL_INTEGRAL;
    end else begin
      cls_o = CL_FRACTIONAL;
    end
  end
endmodule

// File: rtl/rti_round_core.sv
module rti_round_core
  import rti_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] frac_i,
  input  logic             below_one_i,
  input  rmode_e           mode_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] frac_o,
  output logic             inexact_o,
  output logic             carry_o
);
  localparam int SIG_W = MAN_W + 2;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(BIAS + MAN_W);

  logic [EXP_W-1:0] shamt;
  logic [SIG_W-1:0] sig, ulp, half, discard, inc, summed, kept;
  logic             small_one, lost_bits;

  // Magnitude one or more: add an increment, then clear the discarded bits.
  always_comb begin
    sig     = {1'b0, 1'b1, frac_i};
    shamt   = EXP_TOP - exp_i;
    ulp     = SIG_W'(1) << shamt;
    half    = ulp >> 1;
    discard = ulp - SIG_W'(1);
    case (mode_i)
      RM_NEAR_AWAY: inc = half;
      RM_ZERO:      inc = '0;
      RM_UP:        inc = sign_i ? '0 : discard;
      RM_DOWN:      inc = sign_i ? discard : '0;
      default:      inc = ((sig & (ulp | discard)) == half) ? '0 : half;
    endcase
    summed    = sig + inc;
    kept      = summed & ~discard;
    lost_bits = |(sig & discard);
  end

  // Magnitude below one: the result is a signed zero or a signed one.
  always_comb begin
    case (mode_i)
      RM_NEAR_AWAY: small_one = (exp_i == EXP_HALF);
      RM_ZERO:      small_one = 1'b0;
      RM_UP:        small_one = !sign_i;
      RM_DOWN:      small_one = sign_i;
      default:      small_one = (exp_i == EXP_HALF) && (frac_i != '0);
    endcase
  end

  always_comb begin
    if (below_one_i) begin
      exp_o     = small_one ? EXP_ONE : '0;
      frac_o    = '0;
      inexact_o = 1'b1;
      carry_o   = 1'b0;
    end else if (kept[SIG_W-1]) begin
      exp_o     = exp_i + EXP_W'(1);
      frac_o    = kept[MAN_W:1];
      inexact_o = lost_bits;
      carry_o   = 1'b1;
    end else begin
      exp_o     = exp_i;
      frac_o    = kept[MAN_W-1:0];
      inexact_o = lost_bits;
      carry_o   = 1'b0;
    end
  end
endmodule

// File: rtl/rti_nan_unit.sv
module rti_nan_unit #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic                 sign_i,
  input  logic [MAN_W-1:0]     frac_i,
  input  logic                 signaling_i,
  input  logic                 dnan_i,
  output logic [EXP_W+MAN_W:0] res_o,
  output logic                 invalid_o
);
  localparam logic [EXP_W+MAN_W:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  always_comb begin
    invalid_o = signaling_i;
    if (dnan_i) res_o = CANON_NAN;
    else        res_o = {sign_i, {EXP_W{1'b1}}, 1'b1, frac_i[MAN_W-2:0]};
  end
endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral
  import rti_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EXP_W+MAN_W:0] op_i,
  input  logic [2:0]           rmode_i,
  input  logic                 trunc_i,
  input  logic                 dnan_i,
  input  logic                 ftz_i,
  output logic [EXP_W+MAN_W:0] res_o,
  output logic                 invalid_o,
  output logic                 inexact_o
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  opclass_e         cls;
  logic             sign_c;
  logic [EXP_W-1:0] exp_c, exp_r;
  logic [MAN_W-1:0] frac_c, frac_r;
  logic             inexact_r, carry_r, invalid_n;
  logic [W-1:0]     nan_res, res_d;
  logic             inexact_d, invalid_d;
  rmode_e           mode;

  assign mode = decode_mode(rmode_i, trunc_i);

  rti_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
    .op_i(op_i), .ftz_i(ftz_i), .cls_o(cls),
    .sign_o(sign_c), .exp_o(exp_c), .frac_o(frac_c)
  );

  rti_round_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
    .sign_i(sign_c), .exp_i(exp_c), .frac_i(frac_c),
    .below_one_i(cls == CL_BELOW_ONE), .mode_i(mode),
    .exp_o(exp_r), .frac_o(frac_r), .inexact_o(inexact_r), .carry_o(carry_r)
  );

  rti_nan_unit #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan (
    .sign_i(sign_c), .frac_i(frac_c), .signaling_i(cls == CL_SNAN),
    .dnan_i(dnan_i), .res_o(nan_res), .invalid_o(invalid_n)
  );

  always_comb begin
    res_d     = {sign_c, exp_c, frac_c};
    inexact_d = 1'b0;
    invalid_d = 1'b0;
    case (cls)
      CL_QNAN, CL_SNAN: begin
        res_d     = nan_res;
        invalid_d = invalid_n;
      end
      CL_BELOW_ONE, CL_FRACTIONAL: begin
        res_d     = {sign_c, exp_r, frac_r};
        inexact_d = inexact_r;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= invalid_d;
      inexact_o <= inexact_d;
    end
  end

  AST_PASS_INTEGRAL: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_INTEGRAL || cls == CL_INF) |=> (res_o == $past(op_i)) && !inexact_o && !invalid_o); // R1
  AST_INVALID_ONLY_NAN: assert property (@(posedge clk) disable iff (rst)
    invalid_o |-> (res_o[W-2 -: EXP_W] == '1) && res_o[MAN_W-1]); // R2
  AST_NAN_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((res_o[W-2 -: EXP_W] == '1) && (res_o[MAN_W-1:0] != '0)) |-> res_o[MAN_W-1]); // R2
  AST_DEFAULT_NAN: assert property (@(posedge clk) disable iff (rst)
    (dnan_i && (cls == CL_QNAN || cls == CL_SNAN)) |=> res_o == CANON_NAN); // R3
  AST_BELOW_ONE_INEXACT: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_BELOW_ONE) |=> inexact_o); // R4
  AST_CARRY_RENORM: assert property (@(posedge clk) disable iff (rst)
    (carry_r && cls == CL_FRACTIONAL) |=> res_o[MAN_W-1:0] == '0); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(invalid_o && inexact_o)); // R8
  AST_TRUNC_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    (trunc_i && cls == CL_FRACTIONAL) |=> res_o[W-2:0] <= $past(op_i[W-2:0])); // R9
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ftz_i && op_i[W-2 -: EXP_W] == '0) |=> (res_o[W-2:0] == '0) && !inexact_o); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res_o == '0) && !invalid_o && !inexact_o); // R12
endmodule

// File: tb/fp_round_integral_test.sv
module fp_round_integral_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op = '0;
  logic [2:0]  md = '0;
  logic        tr = 1'b0, dn = 1'b0, fz = 1'b0;
  logic [15:0] res;
  logic        inv, inx;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fp_round_integral #(.EXP_W(5), .MAN_W(10)) uut (
    .clk(clk), .rst(rst), .op_i(op), .rmode_i(md), .trunc_i(tr),
    .dnan_i(dn), .ftz_i(fz), .res_o(res), .invalid_o(inv), .inexact_o(inx)
  );

  // Real-valued model of half-precision round-to-integral: {result, invalid, inexact}.
  function automatic logic [17:0] ref_round(input logic [15:0] a, input logic [2:0] code,
                                            input logic t, input logic d, input logic f);
    logic s;
    int e, fr_bits, r, p, eff;
    real m, rem;
    logic [15:0] o;
    s = a[15];
    e = int'(a[14:10]);
    fr_bits = int'(a[9:0]);
    if (e == 31) begin
      if (fr_bits == 0) return {a, 2'b00};
      if (d) return {16'h7E00, !a[9], 1'b0};
      return {a | 16'h0200, !a[9], 1'b0};
    end
    if (e == 0 && f) return {s, 15'd0, 2'b00};
    if (e == 0) m = fr_bits * 2.0 ** (-24);
    else        m = (1024 + fr_bits) * 2.0 ** (e - 25);
    r = $rtoi(m);
    rem = m - r;
    if (rem == 0.0) return {a, 2'b00};
    eff = t ? 1 : (code > 4 ? 0 : int'(code));
    case (eff)
      0: if (rem > 0.5 || (rem == 0.5 && r % 2 == 1)) r++;
      4: if (rem >= 0.5) r++;
      2: if (s) r++;
      3: if (!s) r++;
      default: ;
    endcase
    if (r == 0) o = {s, 15'd0};
    else begin
      p = 0;
      for (int k = 0; k < 16; k++) if (r[k]) p = k;
      o = {s, 5'(p + 15), 10'((r << (10 - p)) & 1023)};
    end
    return {o, 1'b0, 1'b1};
  endfunction

  task automatic run_one(input logic [15:0] a, input logic [2:0] code, input logic t,
                         input logic d, input logic f, input logic [17:0] want, input string tag);
    op = a; md = code; tr = t; dn = d; fz = f;
    @(posedge clk);
    @(negedge clk);
    total++;
    if ({res, inv, inx} !== want) begin
      bad++;
      $display("FAIL %s: op=%h mode=%0d t=%b d=%b f=%b got res=%h inv=%b inx=%b expected res=%h inv=%b inx=%b",
               tag, a, code, t, d, f, res, inv, inx, want[17:2], want[1], want[0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (res !== 16'h0 || inv !== 1'b0 || inx !== 1'b0) begin
      bad++;
      $display("FAIL R12 reset: got res=%h inv=%b inx=%b expected res=0000 inv=0 inx=0", res, inv, inx);
    end
    rst = 1'b0;

    run_one(16'h3E00, 3'd0, 0, 0, 0, {16'h4000, 2'b01}, "R6 1.5 nearest-even");
    run_one(16'h4100, 3'd0, 0, 0, 0, {16'h4000, 2'b01}, "R6 2.5 tie to even");
    run_one(16'h4100, 3'd4, 0, 0, 0, {16'h4200, 2'b01}, "R6 2.5 ties away");
    run_one(16'h3800, 3'd0, 0, 0, 0, {16'h0000, 2'b01}, "R4 0.5 nearest-even");
    run_one(16'h3800, 3'd4, 0, 0, 0, {16'h3C00, 2'b01}, "R4 0.5 ties away");
    run_one(16'h3A00, 3'd0, 0, 0, 0, {16'h3C00, 2'b01}, "R4 0.75 nearest-even");
    run_one(16'hB400, 3'd3, 0, 0, 0, {16'h8000, 2'b01}, "R5 -0.25 up");
    run_one(16'hB400, 3'd2, 0, 0, 0, {16'hBC00, 2'b01}, "R5 -0.25 down");
    run_one(16'hB400, 3'd1, 0, 0, 0, {16'h8000, 2'b01}, "R5 -0.25 zero");
    run_one(16'h63FF, 3'd3, 0, 0, 0, {16'h6400, 2'b01}, "R7 1023.x up carry");
    run_one(16'h4200, 3'd3, 0, 0, 0, {16'h4200, 2'b00}, "R8 exact 3.0");
    run_one(16'h7C00, 3'd2, 0, 0, 0, {16'h7C00, 2'b00}, "R1 infinity");
    run_one(16'hE400, 3'd3, 0, 0, 0, {16'hE400, 2'b00}, "R1 large integral");
    run_one(16'h8000, 3'd2, 0, 0, 0, {16'h8000, 2'b00}, "R1 negative zero");
    run_one(16'h7D01, 3'd0, 0, 0, 0, {16'h7F01, 2'b10}, "R2 signaling NaN");
    run_one(16'hFE05, 3'd0, 0, 0, 0, {16'hFE05, 2'b00}, "R2 quiet NaN");
    run_one(16'hFD01, 3'd0, 0, 1, 0, {16'h7E00, 2'b10}, "R3 default NaN");
    run_one(16'h3E00, 3'd3, 1, 0, 0, {16'h3C00, 2'b01}, "R9 truncate overrides up");
    run_one(16'h8001, 3'd2, 0, 0, 1, {16'h8000, 2'b00}, "R10 flushed subnormal");
    run_one(16'h8001, 3'd2, 0, 0, 0, {16'hBC00, 2'b01}, "R10 subnormal down");
    run_one(16'h4100, 3'd6, 0, 0, 0, {16'h4000, 2'b01}, "R11 code 6 as nearest-even");
    run_one(16'h3E00, 3'd5, 0, 0, 0, {16'h4000, 2'b01}, "R11 code 5 as nearest-even");

    for (int i = 0; i < 65536; i++)
      run_one(16'(i), 3'(i % 8), (i % 11) == 0, (i % 3) == 0, (i % 5) == 0,
              ref_round(16'(i), 3'(i % 8), (i % 11) == 0, (i % 3) == 0, (i % 5) == 0),
              "R6 R11 sweep A");
    for (int i = 0; i < 65536; i++)
      run_one(16'(i), 3'((i + 4) % 8), (i % 17) == 0, (i % 3) != 0, (i % 7) == 0,
              ref_round(16'(i), 3'((i + 4) % 8), (i % 17) == 0, (i % 3) != 0, (i % 7) == 0),
              "R4 R5 sweep B");
    for (int i = 0; i < 30720; i++) begin
      logic [15:0] a;
      a = {1'(i / 15360), 5'(10 + (i % 15360) / 1024), 10'(i % 1024)};
      run_one(a, 3'((i + 2) % 8), 1'b0, 1'b0, 1'b0,
              ref_round(a, 3'((i + 2) % 8), 1'b0, 1'b0, 1'b0), "R6 R7 sweep C");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule